// File: doc/BRIEF.md
# Buffered Serial Transmitter with Parity and Break

This block turns characters into an asynchronous serial bit stream on a single output line. Software-side logic hands it a character through a small write port: one register takes the character itself (eight bits plus an optional ninth), one takes the control bits and one takes the baud divisor. The character is held in a one-entry holding buffer and moves into a shift register at the next frame boundary, so a second character can be queued while the first is still on the line.

A baud generator divides the clock by the programmed divisor to make a tick at sixteen times the bit rate, and a four-bit sub-counter turns sixteen ticks into one bit time. Frames carry eight or nine payload bits, where the last payload slot may be replaced by an even or odd parity bit. A level-held break control sends frames of all zeros. Two flags show whether the holding buffer is free and whether the whole transmitter has gone quiet, and each flag has a gated interrupt request. A loopback output always carries the serial stream for an on-chip receiver, and in loopback mode the external pin is held at mark.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` and `loop_out` are 1 (mark), `tdre` and `tc` are 1, both interrupt requests are 0, and every control bit is 0.
- R2: A frame is one 0 start bit, then payload bits least significant first, then one 1 stop bit. Control bit 1 (nine) = 0 sends `wr_data[7:0]`; nine = 1 also sends `wr_data[8]` of the data write as the ninth payload bit.
- R3: With control bit 2 (parity enable) set, the last payload slot carries parity over the payload bits before it; control bit 3 = 0 makes the count of ones in those bits plus parity even, = 1 makes it odd. Frames are then 10 bits (nine = 0) or 11 bits (nine = 1) long.
- R4: Each bit lasts 16 × D clock cycles, D being `wr_data[12:0]` of the last write with `wr_sel` = 2; the line changes only on a baud tick or when the transmitter is turned off. D = 0 stops the baud generator, so no frame starts.
- R5: A write with `wr_sel` = 0 makes `tdre` 0 from the next cycle; `tdre` returns to 1 when the character enters the shift register. A data write in the same cycle as that transfer is kept in the buffer and sent as the next frame.
- R6: `tc` is 1 only when the buffer is empty, no frame is shifting and no break is requested; while `tc` is 1 the loopback line is at mark.
- R7: A buffered character starts its start bit in the cycle right after the previous stop bit ends, with no idle gap.
- R8: While control bit 4 (break) is 1 and the transmitter is on, every new frame is all zeros for the full frame length, including the stop slot; a buffered character waits (`tdre` stays 0) and is sent after the first frame boundary following the release of break.
- R9: `irq_tdre` equals `tdre` AND control bit 5; `irq_tc` equals `tc` AND control bit 6.
- R10: With control bit 0 (transmit enable) at 0 both lines stay at mark, no frame starts and a buffered character is kept for the time the bit is set again.
- R11: With control bit 7 (loopback) set, `txd` is held at 1 while `loop_out` carries the frames; `loop_out` carries the frames in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 data, 1 control, 2 divisor |
| wr_data | input | WR_W (13) | Write data |
| txd | output | 1 | Serial output pin |
| loop_out | output | 1 | Internal serial stream for a companion receiver |
| tdre | output | 1 | Holding buffer free for a new character |
| tc | output | 1 | Transmitter fully idle |
| irq_tdre | output | 1 | Buffer-free interrupt request |
| irq_tc | output | 1 | Transmit-complete interrupt request |

## Verification
The delicate cycle is the one where a data write lands on the same clock edge that moves the previous character from the buffer into the shift register. The bench provokes it by holding the write strobe for two consecutive cycles with the line idle and a divisor of 1, so the second write meets the transfer of the first. It then judges that `tdre` stays low, that the first frame is intact and that the second character follows with no gap, which shows the write won over the buffer clear.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   localparam logic [1:0] SEL_DATA = 2'd0;
   localparam logic [1:0] SEL_CTRL = 2'd1;
   localparam logic [1:0] SEL_DIV  = 2'd2;

   localparam int CHAR_BITS  = 9;
   localparam int FRAME_BITS = 11;

   typedef struct packed {
      logic loop_en;
      logic tc_ie;
      logic tdre_ie;
      logic brk;
      logic par_odd;
      logic par_en;
      logic nine;
      logic tx_en;
   } ctrl_t;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int DIV_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             restart,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = (div != '0) && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= div - DIV_W'(1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - DIV_W'(1);
   end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int OVS_W  = 4,
   parameter bit PAR_ON = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 enable,
   input  logic                 nine,
   input  logic                 par_en,
   input  logic                 par_odd,
   input  logic                 brk,
   input  logic                 pend,
   input  logic [CHAR_BITS-1:0] pend_data,
   output logic                 take,
   output logic                 busy,
   output logic                 line
);

   localparam int OVS = 1 << OVS_W;

   logic [FRAME_BITS-1:0] sh_q;
   logic [FRAME_BITS-1:0] frame;
   logic [3:0]            bcnt_q;
   logic [OVS_W-1:0]      sub_q;
   logic                  busy_q;
   logic [3:0]            last_idx;
   logic                  bit_end, frame_end, start_ok;
   logic                  par_bit, par_use;
   logic [7:0]            pmask;

   assign pmask = nine ? 8'hFF : 8'h7F;

   generate
      if (PAR_ON) begin : g_par
         assign par_bit = (^(pend_data[7:0] & pmask)) ^ par_odd;
         assign par_use = par_en;
      end else begin : g_nopar
         assign par_bit = 1'b0;
         assign par_use = 1'b0;
      end
   endgenerate

   assign last_idx  = nine ? 4'd10 : 4'd9;
   assign bit_end   = busy_q && tick && (sub_q == OVS_W'(OVS - 1));
   assign frame_end = bit_end && (bcnt_q == last_idx);
   assign start_ok  = enable && tick && (brk || pend) && (!busy_q || frame_end);
   assign take      = start_ok && !brk;

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < CHAR_BITS; i++) begin
         if (i < 8 || nine)
            frame[1+i] = pend_data[i];
      end
      if (par_use)
         frame[last_idx - 4'd1] = par_bit;
      if (brk) begin
         for (int i = 0; i < FRAME_BITS; i++) begin
            if (4'(i) <= last_idx)
               frame[i] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         bcnt_q <= '0;
         sub_q  <= '0;
         busy_q <= 1'b0;
      end else if (!enable) begin
         sh_q   <= '1;
         bcnt_q <= '0;
         sub_q  <= '0;
         busy_q <= 1'b0;
      end else if (start_ok) begin
         sh_q   <= frame;
         bcnt_q <= '0;
         sub_q  <= '0;
         busy_q <= 1'b1;
      end else if (frame_end) begin
         sh_q   <= '1;
         busy_q <= 1'b0;
      end else if (bit_end) begin
         sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
         bcnt_q <= bcnt_q + 4'd1;
         sub_q  <= '0;
      end else if (busy_q && tick) begin
         sub_q  <= sub_q + OVS_W'(1);
      end
   end

   assign busy = busy_q;
   assign line = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
   import sertx_pkg::*;
#(
   parameter int DIV_W   = 13,
   parameter int WR_W    = 13,
   parameter int OVS_W   = 4,
   parameter int RST_DIV = 52,
   parameter bit PAR_ON  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_sel,
   input  logic [WR_W-1:0] wr_data,
   output logic            txd,
   output logic            loop_out,
   output logic            tdre,
   output logic            tc,
   output logic            irq_tdre,
   output logic            irq_tc
);

   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div
         $error("sertx_top: DIV_W must lie in 2..16");
      end
      if (WR_W < DIV_W || WR_W < CHAR_BITS) begin : g_bad_wr
         $error("sertx_top: WR_W too narrow for divisor or character");
      end
      if (OVS_W < 1 || OVS_W > 6) begin : g_bad_ovs
         $error("sertx_top: OVS_W must lie in 1..6");
      end
   endgenerate

   ctrl_t                ctrl_q;
   logic [DIV_W-1:0]     div_q;
   logic [CHAR_BITS-1:0] buf_q;
   logic                 full_q;
   logic                 wr_dat, wr_ctl, wr_div;
   logic                 tick, take, busy, line;

   assign wr_dat = wr_en && (wr_sel == SEL_DATA);
   assign wr_ctl = wr_en && (wr_sel == SEL_CTRL);
   assign wr_div = wr_en && (wr_sel == SEL_DIV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         div_q  <= DIV_W'(RST_DIV);
         buf_q  <= '0;
         full_q <= 1'b0;
      end else begin
         if (wr_ctl)
            ctrl_q <= ctrl_t'(wr_data[7:0]);
         if (wr_div)
            div_q <= wr_data[DIV_W-1:0];
         if (wr_dat) begin
            buf_q  <= wr_data[CHAR_BITS-1:0];
            full_q <= 1'b1;
         end else if (take) begin
            full_q <= 1'b0;
         end
      end
   end

   sertx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .div     (div_q),
      .restart (wr_div),
      .tick    (tick)
   );

   sertx_shift #(.OVS_W(OVS_W), .PAR_ON(PAR_ON)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .enable    (ctrl_q.tx_en),
      .nine      (ctrl_q.nine),
      .par_en    (ctrl_q.par_en),
      .par_odd   (ctrl_q.par_odd),
      .brk       (ctrl_q.brk),
      .pend      (full_q),
      .pend_data (buf_q),
      .take      (take),
      .busy      (busy),
      .line      (line)
   );

   assign loop_out = line;
   assign txd      = ctrl_q.loop_en ? 1'b1 : line;
   assign tdre     = !full_q;
   assign tc       = !full_q && !busy && !(ctrl_q.brk && ctrl_q.tx_en);
   assign irq_tdre = tdre && ctrl_q.tdre_ie;
   assign irq_tc   = tc && ctrl_q.tc_ie;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_sel,
   input logic       txd,
   input logic       loop_out,
   input logic       tdre,
   input logic       tc,
   input logic       irq_tdre,
   input logic       irq_tc,
   input logic       tick,
   input logic       tx_en,
   input logic       loop_en
);

   AST_TC_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> loop_out);  // R6
   AST_TC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> tdre);  // R6
   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> !tdre);  // R5
   AST_IRQ_TDRE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tdre |-> tdre);  // R9
   AST_IRQ_TC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tc |-> tc);  // R9
   AST_LOOP_PIN_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> txd);  // R11
   AST_OFF_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> loop_out);  // R10
   AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_out != $past(loop_out)) |-> ($past(tick) || !$past(tx_en)));  // R4

endmodule

bind sertx_top sertx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .txd      (txd),
   .loop_out (loop_out),
   .tdre     (tdre),
   .tc       (tc),
   .irq_tdre (irq_tdre),
   .irq_tc   (irq_tc),
   .tick     (tick),
   .tx_en    (ctrl_q.tx_en),
   .loop_en  (ctrl_q.loop_en)
);

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [12:0] wr_data = '0;
   logic        txd, loop_out, tdre, tc, irq_tdre, irq_tc;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   sertx_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .txd(txd), .loop_out(loop_out), .tdre(tdre), .tc(tc),
      .irq_tdre(irq_tdre), .irq_tc(irq_tc)
   );

   // stimulus vectors: [11] nine, [10] parity on, [9] odd, [8:0] character
   localparam logic [11:0] VEC [7] = '{
      12'h055, 12'h0A3, 12'h93C, 12'h454, 12'h654, 12'hCFF, 12'hE81
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [12:0] cw(input bit en, input bit nine, input bit pe,
                                      input bit po, input bit brk, input bit tie,
                                      input bit tcie, input bit lp);
      return {5'd0, lp, tcie, tie, brk, po, pe, nine, en};
   endfunction

   function automatic logic [10:0] exp_frame(input logic [11:0] v);
      logic [10:0] f;
      int nd;
      logic p;
      nd = v[11] ? 9 : 8;
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < nd; i++) f[1+i] = v[i];
      if (v[10]) begin
         p = v[9];
         for (int i = 0; i < nd - 1; i++) p = p ^ v[i];
         f[nd] = p;
      end
      f[nd+1] = 1'b1;
      return f;
   endfunction

   function automatic logic ln(input bit lp);
      return lp ? loop_out : txd;
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [12:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_start(input bit lp, input string tag);
      int n = 0;
      while (ln(lp) !== 1'b0 && n < 4000) begin
         @(negedge clk); n++;
      end
      if (n >= 4000) chk(1'b0, {tag, " start bit never seen"}, 1, 0);
   endtask

   // called at the first negedge of a start bit; returns at the first negedge after the frame
   task automatic sample_frame(input bit lp, input int nb, input int bc,
                               output logic [10:0] bits, output bit pin_high);
      bits = '1;
      pin_high = 1'b1;
      repeat (bc/2) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         if (i > 0) repeat (bc) @(negedge clk);
         bits[i] = ln(lp);
         if (txd !== 1'b1) pin_high = 1'b0;
      end
      repeat (bc/2) @(negedge clk);
   endtask

   task automatic wait_tc();
      int n = 0;
      while (tc !== 1'b1 && n < 4000) begin
         @(negedge clk); n++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [10:0] got;
      logic [10:0] ex;
      bit hi;
      int n;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(txd === 1'b1 && loop_out === 1'b1, "R1 lines at mark", {txd, loop_out}, 3);
      chk(tdre === 1'b1 && tc === 1'b1, "R1 flags set", {tdre, tc}, 3);
      chk(irq_tdre === 1'b0 && irq_tc === 1'b0, "R1 R9 irqs low", {irq_tdre, irq_tc}, 0);
      rst_n = 1'b1;

      wr(2'd2, 13'd1);

      // R2 R3 vector table
      foreach (VEC[k]) begin
         wr(2'd1, cw(1, VEC[k][11], VEC[k][10], VEC[k][9], 0, 0, 0, 0));
         wr(2'd0, {4'd0, VEC[k][8:0]});
         wait_start(0, "R2");
         sample_frame(0, VEC[k][11] ? 11 : 10, 16, got, hi);
         ex = exp_frame(VEC[k]);
         if (!VEC[k][11]) begin got[10] = 1'b1; ex[10] = 1'b1; end
         chk(got === ex, $sformatf("R2 R3 frame vector %0d", k), got, ex);
         wait_tc();
      end

      // R5 R7 write in the same cycle as the transfer, then back-to-back frames
      wr(2'd1, cw(1, 0, 0, 0, 0, 0, 0, 0));
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 13'h0C5;
      @(negedge clk);
      wr_data = 13'h03A;
      @(negedge clk);
      wr_en = 1'b0;
      chk(tdre === 1'b0, "R5 write during transfer kept", tdre, 0);
      chk(txd === 1'b0, "R5 first frame started", txd, 0);
      sample_frame(0, 10, 16, got, hi);
      ex = exp_frame(12'h0C5);
      chk(got[9:0] === ex[9:0], "R5 first frame", got[9:0], ex[9:0]);
      chk(txd === 1'b0 && tdre === 1'b1, "R7 second start without gap", {txd, tdre}, 1);
      chk(tc === 1'b0, "R6 tc low while shifting", tc, 0);
      sample_frame(0, 10, 16, got, hi);
      ex = exp_frame(12'h03A);
      chk(got[9:0] === ex[9:0], "R7 second frame", got[9:0], ex[9:0]);
      chk(tc === 1'b1 && txd === 1'b1, "R6 tc after last stop", {tc, txd}, 3);

      // R4 divisor of 3: start bit lasts 48 cycles
      wr(2'd2, 13'd3);
      wr(2'd0, 13'h001);
      wait_start(0, "R4");
      n = 0;
      while (txd === 1'b0 && n < 500) begin n++; @(negedge clk); end
      chk(n == 48, "R4 bit time 16*D", n, 48);
      wait_tc();
      // R4 divisor zero halts
      wr(2'd2, 13'd0);
      wr(2'd0, 13'h0F0);
      hi = 1'b1;
      repeat (100) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
      chk(hi && tdre === 1'b0, "R4 divisor zero holds character", {hi, tdre}, 2);
      wr(2'd2, 13'd1);
      wait_start(0, "R4");
      sample_frame(0, 10, 16, got, hi);
      ex = exp_frame(12'h0F0);
      chk(got[9:0] === ex[9:0], "R4 resumed frame", got[9:0], ex[9:0]);
      wait_tc();

      // R8 break
      wr(2'd1, cw(1, 0, 0, 0, 1, 0, 0, 0));
      chk(tc === 1'b0, "R6 tc low with break requested", tc, 0);
      wait_start(0, "R8");
      sample_frame(0, 10, 16, got, hi);
      chk(got[9:0] === 10'd0, "R8 break frame all zero", got[9:0], 0);
      chk(txd === 1'b0, "R8 break continues while held", txd, 0);
      wr(2'd0, 13'h1A5);
      repeat (170) @(negedge clk);
      chk(tdre === 1'b0, "R8 character waits during break", tdre, 0);
      wr(2'd1, cw(1, 0, 0, 0, 0, 0, 0, 0));
      n = 0;
      while (tdre !== 1'b1 && n < 400) begin @(negedge clk); n++; end
      sample_frame(0, 10, 16, got, hi);
      ex = exp_frame(12'h0A5);
      chk(got[9:0] === ex[9:0], "R8 character after break", got[9:0], ex[9:0]);
      wait_tc();

      // R10 transmitter off
      wr(2'd1, cw(0, 0, 0, 0, 0, 0, 0, 0));
      wr(2'd0, 13'h066);
      hi = 1'b1;
      repeat (60) begin @(negedge clk); if (txd !== 1'b1 || loop_out !== 1'b1) hi = 1'b0; end
      chk(hi, "R10 lines stay at mark when off", hi, 1);
      chk(tdre === 1'b0 && tc === 1'b0, "R10 character kept", {tdre, tc}, 0);
      wr(2'd1, cw(1, 0, 0, 0, 0, 0, 0, 0));
      wait_start(0, "R10");
      sample_frame(0, 10, 16, got, hi);
      ex = exp_frame(12'h066);
      chk(got[9:0] === ex[9:0], "R10 kept character sent", got[9:0], ex[9:0]);
      wait_tc();

      // R11 loopback
      wr(2'd1, cw(1, 0, 0, 0, 0, 0, 0, 1));
      wr(2'd0, 13'h0B2);
      wait_start(1, "R11");
      sample_frame(1, 10, 16, got, hi);
      ex = exp_frame(12'h0B2);
      chk(got[9:0] === ex[9:0], "R11 loop_out frame", got[9:0], ex[9:0]);
      chk(hi, "R11 pin held at mark", hi, 1);
      wait_tc();

      // R9 interrupt gating
      wr(2'd1, cw(1, 0, 0, 0, 0, 1, 0, 0));
      chk(irq_tdre === 1'b1 && irq_tc === 1'b0, "R9 tdre irq only", {irq_tdre, irq_tc}, 2);
      wr(2'd1, cw(1, 0, 0, 0, 0, 0, 1, 0));
      chk(irq_tdre === 1'b0 && irq_tc === 1'b1, "R9 tc irq only", {irq_tdre, irq_tc}, 1);
      wr(2'd0, 13'h011);
      chk(irq_tc === 1'b0, "R9 tc irq drops on write", irq_tc, 0);
      wait_tc();
      chk(irq_tc === 1'b1, "R9 tc irq after frame", irq_tc, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule